// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a 32-bit processor core that completes one instruction on every clock edge. It fetches from a small internal word-addressed program store, reads two operands from a 32-entry register file, and uses one adder/subtractor with a zero flag. It then writes back either the arithmetic result or a word read from a small internal data store. The instruction set is deliberately narrow: register-register add and subtract, word load, word store, and the two equality branches. Any other opcode retires as a no-operation.

Both stores are filled through a shared load port while the core is held in reset. A small control state machine has two states, `ST_HOLD` and `ST_EXEC`. Reset forces `ST_HOLD`, in which the program counter sits at zero and nothing is written. The only transition, `ST_HOLD -> ST_EXEC`, is taken on the first clock edge after reset is released. `ST_EXEC` then holds until the next reset. Three commit outputs report, in the cycle before the edge that performs them, the current program counter, the register write and the data-store write.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low, `ld_imem_we` / `ld_dmem_we` write `ld_data` to word `ld_addr` of the program or data store, `pc_o` is 0 and both write strobes are low. In the first cycle after release (`ST_HOLD`), `pc_o` is 0 and neither strobe is high. Execution of word 0 starts in the following cycle.
- R2: Opcode 0x00 (bits 31-26) is register-register. Function code 0x22 (bits 5-0) subtracts and any other function code adds. The first operand is the register at bits 25-21, the second is the register at bits 20-16, and the result goes to the register at bits 15-11.
- R3: Opcode 0x23 loads a word. The address is register[25-21] plus the sign-extended bits 15-0, the word index is address bits [N+1:2], and the word read is written to register[20-16].
- R4: Opcode 0x2B stores register[20-16] at an address formed as in R3 and writes no register. A later load from that address returns the stored word.
- R5: Opcode 0x04 branches when the two source registers are equal. The target is PC+4 plus the sign-extended offset shifted left by 2, and negative offsets are allowed.
- R6: Opcode 0x05 branches to the same target when the two source registers differ.
- R7: Every instruction that is not a taken branch moves the PC to PC+4.
- R8: Register 0 reads as zero. A write addressed to it is still shown on the commit outputs but leaves it unchanged.
- R9: Any other opcode writes neither a register nor the data store, and the PC advances by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset; load port active while low |
| ld_imem_we | input | 1 | Load-port write to program store |
| ld_dmem_we | input | 1 | Load-port write to data store |
| ld_addr | input | 6 | Load-port word index |
| ld_data | input | 32 | Load-port write data |
| pc_o | output | 32 | Program counter of the instruction now executing |
| rf_we_o | output | 1 | Register write at the next edge |
| rf_waddr_o | output | 5 | Destination register of that write |
| rf_wdata_o | output | 32 | Value of that write |
| dm_we_o | output | 1 | Data-store write at the next edge |
| dm_addr_o | output | 32 | Byte address of that write |
| dm_wdata_o | output | 32 | Value of that write |

## Verification
A preloaded program chains loads into adds and subtracts, so wrong field slicing or a swapped operand select shows up as a wrong write-back value rather than a missing one. A store followed by a load from the same address separates the store path from the read path. A load with a negative offset checks sign extension. Branches are exercised as equal taken, equal not taken, not-equal taken, not-equal not taken and a backward self-loop, which tells an inverted zero flag apart from a wrong target computation. An unknown opcode and writes to and reads from register 0 cover the cases that must leave state alone.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;

    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_LW    = 6'h23;
    localparam logic [5:0] OP_SW    = 6'h2B;
    localparam logic [5:0] OP_BEQ   = 6'h04;
    localparam logic [5:0] OP_BNE   = 6'h05;

    localparam logic [5:0] FN_ADD   = 6'h20;
    localparam logic [5:0] FN_SUB   = 6'h22;

    typedef enum logic [1:0] {
        AOP_ADD   = 2'b00,
        AOP_SUB   = 2'b01,
        AOP_FUNCT = 2'b10
    } aluop_t;

    typedef enum logic {
        ALU_ADD = 1'b0,
        ALU_SUB = 1'b1
    } alufn_t;

    typedef enum logic {
        ST_HOLD = 1'b0,
        ST_EXEC = 1'b1
    } core_state_t;

    typedef struct packed {
        logic   dst_is_rd;
        logic   opb_is_imm;
        logic   wb_from_mem;
        logic   reg_write;
        logic   mem_write;
        logic   br_eq;
        logic   br_ne;
        aluop_t alu_op;
    } ctrl_t;

endpackage

// File: rtl/sc_ctrl.sv
module sc_ctrl
    import sc_core_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctrl,
    output alufn_t     alu_fn
);

    always_comb begin
        ctrl = '0;
        ctrl.alu_op = AOP_ADD;
        unique case (opcode)
            OP_RTYPE: begin
                ctrl.dst_is_rd = 1'b1;
                ctrl.reg_write = 1'b1;
                ctrl.alu_op    = AOP_FUNCT;
            end
            OP_LW: begin
                ctrl.opb_is_imm  = 1'b1;
                ctrl.wb_from_mem = 1'b1;
                ctrl.reg_write   = 1'b1;
            end
            OP_SW: begin
                ctrl.opb_is_imm = 1'b1;
                ctrl.mem_write  = 1'b1;
            end
            OP_BEQ: begin
                ctrl.br_eq  = 1'b1;
                ctrl.alu_op = AOP_SUB;
            end
            OP_BNE: begin
                ctrl.br_ne  = 1'b1;
                ctrl.alu_op = AOP_SUB;
            end
            default: ctrl = '0;
        endcase
    end

    always_comb begin
        unique case (ctrl.alu_op)
            AOP_SUB:   alu_fn = ALU_SUB;
            AOP_FUNCT: alu_fn = (funct == FN_SUB) ? ALU_SUB : ALU_ADD;
            default:   alu_fn = ALU_ADD;
        endcase
    end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int XLEN = 32,
    parameter int RAW  = 5
) (
    input  logic            clk,
    input  logic            we,
    input  logic [RAW-1:0]  waddr,
    input  logic [XLEN-1:0] wdata,
    input  logic [RAW-1:0]  raddr_a,
    input  logic [RAW-1:0]  raddr_b,
    output logic [XLEN-1:0] rdata_a,
    output logic [XLEN-1:0] rdata_b
);

    localparam int NREG = 1 << RAW;

    logic [XLEN-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (we && (waddr != '0)) begin
            regs[waddr] <= wdata;
        end
    end

    assign rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
    assign rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];

endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_core_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    input  alufn_t          fn,
    output logic [XLEN-1:0] res,
    output logic            zero
);

    always_comb begin
        unique case (fn)
            ALU_SUB: res = opa - opb;
            default: res = opa + opb;
        endcase
    end

    assign zero = (res == '0);

endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_core_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    parameter int LDW        = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ld_imem_we,
    input  logic            ld_dmem_we,
    input  logic [LDW-1:0]  ld_addr,
    input  logic [XLEN-1:0] ld_data,
    output logic [XLEN-1:0] pc_o,
    output logic            rf_we_o,
    output logic [4:0]      rf_waddr_o,
    output logic [XLEN-1:0] rf_wdata_o,
    output logic            dm_we_o,
    output logic [XLEN-1:0] dm_addr_o,
    output logic [XLEN-1:0] dm_wdata_o
);

    localparam int IAW = $clog2(IMEM_WORDS);
    localparam int DAW = $clog2(DMEM_WORDS);
    localparam int RAW = 5;
    localparam int IMW = 16;

    core_state_t     state_q, state_d;
    logic [XLEN-1:0] pc_q, pc_next, pc_plus4, br_target;
    logic [XLEN-1:0] instr;
    logic [5:0]      opcode, funct;
    logic [RAW-1:0]  rs_idx, rt_idx, rd_idx, dst_idx;
    logic [XLEN-1:0] rs_val, rt_val, imm_sext, opb, alu_y, mem_rdata, wb_val;
    logic            alu_zero, take_br, run;
    ctrl_t           ctrl;
    alufn_t          alu_fn;

    logic [XLEN-1:0] imem [IMEM_WORDS];
    logic [XLEN-1:0] dmem [DMEM_WORDS];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    // next state and per-state outputs
    always_comb begin
        state_d = state_q;
        run     = 1'b0;
        unique case (state_q)
            ST_HOLD: state_d = ST_EXEC;
            ST_EXEC: begin
                state_d = ST_EXEC;
                run     = 1'b1;
            end
            default: state_d = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   pc_q <= '0;
        else if (run) pc_q <= pc_next;
    end

    always_ff @(posedge clk) begin
        if (!rst_n && ld_imem_we) imem[ld_addr[IAW-1:0]] <= ld_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            if (ld_dmem_we) dmem[ld_addr[DAW-1:0]] <= ld_data;
        end else if (run && ctrl.mem_write) begin
            dmem[alu_y[DAW+1:2]] <= rt_val;
        end
    end

    assign instr  = imem[pc_q[IAW+1:2]];
    assign opcode = instr[31:26];
    assign rs_idx = instr[25:21];
    assign rt_idx = instr[20:16];
    assign rd_idx = instr[15:11];
    assign funct  = instr[5:0];

    assign imm_sext = {{(XLEN-IMW){instr[IMW-1]}}, instr[IMW-1:0]};

    sc_ctrl u_ctrl (
        .opcode (opcode),
        .funct  (funct),
        .ctrl   (ctrl),
        .alu_fn (alu_fn)
    );

    assign dst_idx = ctrl.dst_is_rd ? rd_idx : rt_idx;

    sc_regfile #(.XLEN(XLEN), .RAW(RAW)) u_rf (
        .clk     (clk),
        .we      (run && ctrl.reg_write),
        .waddr   (dst_idx),
        .wdata   (wb_val),
        .raddr_a (rs_idx),
        .raddr_b (rt_idx),
        .rdata_a (rs_val),
        .rdata_b (rt_val)
    );

    assign opb = ctrl.opb_is_imm ? imm_sext : rt_val;

    sc_alu #(.XLEN(XLEN)) u_alu (
        .opa  (rs_val),
        .opb  (opb),
        .fn   (alu_fn),
        .res  (alu_y),
        .zero (alu_zero)
    );

    assign mem_rdata = dmem[alu_y[DAW+1:2]];
    assign wb_val    = ctrl.wb_from_mem ? mem_rdata : alu_y;

    assign pc_plus4  = pc_q + XLEN'(4);
    assign br_target = pc_plus4 + (imm_sext << 2);
    assign take_br   = (ctrl.br_eq && alu_zero) || (ctrl.br_ne && !alu_zero);
    assign pc_next   = take_br ? br_target : pc_plus4;

    assign pc_o       = pc_q;
    assign rf_we_o    = run && ctrl.reg_write;
    assign rf_waddr_o = dst_idx;
    assign rf_wdata_o = wb_val;
    assign dm_we_o    = run && ctrl.mem_write;
    assign dm_addr_o  = alu_y;
    assign dm_wdata_o = rt_val;

    logic unused_bits;
    assign unused_bits = ^{instr[10:6], ld_addr, pc_q[1:0], pc_q[XLEN-1:IAW+2],
                           alu_y[1:0], alu_y[XLEN-1:DAW+2]};

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
    import sc_core_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            run,
    input logic [5:0]      opcode,
    input logic [XLEN-1:0] pc_o,
    input logic            rf_we_o,
    input logic            dm_we_o,
    input logic [XLEN-1:0] rs_val,
    input logic [XLEN-1:0] rt_val,
    input logic [XLEN-1:0] imm_sext
);

    logic known_op;
    assign known_op = (opcode == OP_RTYPE) || (opcode == OP_LW) || (opcode == OP_SW) ||
                      (opcode == OP_BEQ) || (opcode == OP_BNE);

    p_hold_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (!rf_we_o && !dm_we_o && pc_o == '0));

    p_store_no_wb_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dm_we_o |-> !rf_we_o);

    p_beq_taken_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && opcode == OP_BEQ && rs_val == rt_val)
        |=> pc_o == $past(pc_o) + XLEN'(4) + ($past(imm_sext) << 2));

    p_bne_taken_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && opcode == OP_BNE && rs_val != rt_val)
        |=> pc_o == $past(pc_o) + XLEN'(4) + ($past(imm_sext) << 2));

    p_seq_pc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && opcode != OP_BEQ && opcode != OP_BNE)
        |=> pc_o == $past(pc_o) + XLEN'(4));

    p_unknown_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !known_op) |-> (!rf_we_o && !dm_we_o));

endmodule

bind sc_core sc_core_chk #(.XLEN(XLEN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .opcode   (opcode),
    .pc_o     (pc_o),
    .rf_we_o  (rf_we_o),
    .dm_we_o  (dm_we_o),
    .rs_val   (rs_val),
    .rt_val   (rt_val),
    .imm_sext (imm_sext)
);

// File: tb/sc_core_tb.sv
module sc_core_tb_top;

    localparam int NSTEP = 24;

    typedef struct packed {
        logic [31:0] pc;
        logic        we;
        logic [4:0]  wa;
        logic [31:0] wd;
        logic        mwe;
        logic [31:0] ma;
        logic [31:0] md;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_imem_we = 1'b0, ld_dmem_we = 1'b0;
    logic [5:0]  ld_addr = '0;
    logic [31:0] ld_data = '0;
    logic [31:0] pc_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
    logic        rf_we_o, dm_we_o;
    logic [4:0]  rf_waddr_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit mon_go = 1'b0;

    item_t exp_q[$];
    string tag_q[$];

    logic [31:0] prog [64];
    logic [31:0] mreg [32];
    logic [31:0] mmem [64];

    always #10 clk = ~clk;

    sc_core dut_i (
        .clk(clk), .rst_n(rst_n), .ld_imem_we(ld_imem_we), .ld_dmem_we(ld_dmem_we),
        .ld_addr(ld_addr), .ld_data(ld_data), .pc_o(pc_o), .rf_we_o(rf_we_o),
        .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o), .dm_we_o(dm_we_o),
        .dm_addr_o(dm_addr_o), .dm_wdata_o(dm_wdata_o)
    );

    function automatic logic [31:0] enc_r(input int rd, input int rs, input int rt, input logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input int off);
        return {op, 5'(rs), 5'(rt), 16'(off)};
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // reference model: computes expected commit for each instruction
    task automatic drive_expected(input int nstep);
        logic [31:0] pc = 0;
        for (int s = 0; s < nstep; s++) begin
            logic [31:0] ins, a, b, sx, nxt;
            item_t it;
            string tag;
            ins = prog[pc[7:2]];
            a = (ins[25:21] == 0) ? 32'd0 : mreg[ins[25:21]];
            b = (ins[20:16] == 0) ? 32'd0 : mreg[ins[20:16]];
            sx = {{16{ins[15]}}, ins[15:0]};
            it = '0;
            it.pc = pc;
            nxt = pc + 4;
            tag = "R9";
            case (ins[31:26])
                6'h00: begin
                    it.we = 1; it.wa = ins[15:11];
                    it.wd = (ins[5:0] == 6'h22) ? a - b : a + b;
                    tag = (ins[15:11] == 0 || ins[25:21] == 0) ? "R8" : "R2";
                end
                6'h23: begin
                    it.we = 1; it.wa = ins[20:16]; it.wd = mmem[(a + sx) >> 2];
                    tag = "R3";
                end
                6'h2B: begin
                    it.mwe = 1; it.ma = a + sx; it.md = b;
                    mmem[(a + sx) >> 2] = b;
                    tag = "R4";
                end
                6'h04: begin
                    if (a == b) nxt = pc + 4 + (sx << 2);
                    tag = "R5";
                end
                6'h05: begin
                    if (a != b) nxt = pc + 4 + (sx << 2);
                    tag = "R6";
                end
                default: tag = "R9";
            endcase
            if (it.we && it.wa != 0) mreg[it.wa] = it.wd;
            exp_q.push_back(it);
            tag_q.push_back(tag);
            pc = nxt;
        end
    endtask

    // monitor: one expected commit per cycle once execution starts
    initial begin
        wait (mon_go);
        forever begin
            @(negedge clk);
            if (exp_q.size() != 0) begin
                item_t e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check((t == "R5" || t == "R6") ? t : "R7", "pc", pc_o, e.pc);
                check(t, "rf_we", 32'(rf_we_o), 32'(e.we));
                check(t, "dm_we", 32'(dm_we_o), 32'(e.mwe));
                if (e.we && rf_we_o) begin
                    check(t, "rf_waddr", 32'(rf_waddr_o), 32'(e.wa));
                    check(t, "rf_wdata", rf_wdata_o, e.wd);
                end
                if (e.mwe && dm_we_o) begin
                    check(t, "dm_addr", dm_addr_o, e.ma);
                    check(t, "dm_wdata", dm_wdata_o, e.md);
                end
                if (exp_q.size() == 0) done = 1'b1;
            end
        end
    end

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) begin prog[i] = '0; mmem[i] = '0; end
        for (int i = 0; i < 32; i++) mreg[i] = '0;
        prog[0]  = enc_i(6'h23, 0, 1, 0);
        prog[1]  = enc_i(6'h23, 0, 2, 4);
        prog[2]  = enc_r(3, 1, 2, 6'h20);
        prog[3]  = enc_r(4, 1, 2, 6'h22);
        prog[4]  = enc_i(6'h2B, 0, 3, 16);
        prog[5]  = enc_i(6'h23, 0, 5, 16);
        prog[6]  = enc_r(0, 1, 2, 6'h20);
        prog[7]  = enc_r(6, 0, 1, 6'h20);
        prog[8]  = enc_i(6'h23, 0, 7, 12);
        prog[9]  = enc_i(6'h04, 1, 7, 2);
        prog[10] = enc_r(8, 1, 1, 6'h20);
        prog[11] = enc_r(8, 2, 2, 6'h20);
        prog[12] = enc_i(6'h05, 1, 7, 5);
        prog[13] = enc_i(6'h05, 1, 2, 1);
        prog[14] = enc_r(9, 1, 1, 6'h20);
        prog[15] = enc_i(6'h23, 3, 9, -4);
        prog[16] = 32'hFC00_0000;
        prog[17] = enc_i(6'h04, 1, 2, 3);
        prog[18] = enc_i(6'h04, 3, 5, -1);
        mmem[0] = 32'd5;
        mmem[1] = 32'd7;
        mmem[2] = 32'hFFFF_FFFD;
        mmem[3] = 32'd5;

        // preload through the load port while in reset
        for (int i = 0; i < 19; i++) begin
            @(negedge clk);
            ld_imem_we = 1'b1; ld_dmem_we = 1'b0; ld_addr = 6'(i); ld_data = prog[i];
        end
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            ld_imem_we = 1'b0; ld_dmem_we = 1'b1; ld_addr = 6'(i); ld_data = mmem[i];
        end
        @(negedge clk);
        ld_imem_we = 1'b0; ld_dmem_we = 1'b0;
        check("R1", "pc in reset", pc_o, 32'd0);
        check("R1", "strobes in reset", 32'({rf_we_o, dm_we_o}), 32'd0);

        drive_expected(NSTEP);

        rst_n = 1'b1;
        #1;
        check("R1", "pc in hold", pc_o, 32'd0);
        check("R1", "strobes in hold", 32'({rf_we_o, dm_we_o}), 32'd0);
        @(posedge clk);
        mon_go = 1'b1;
        wait (done);
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule